// File: doc/BRIEF.md
# Video Mode Frame and Line Sequencer

This block produces the timing skeleton of a serial display link that runs in video mode. It runs on the link byte clock. It walks through a frame line by line and through each line byte cycle by byte cycle. For every cycle it reports which horizontal region the link is in, and which vertical phase the current line belongs to. It also says whether the link may drop to low power. One-cycle strobes mark the start of each line, the start of each pixel packet and the start of each null filler packet. The serialiser, the lane distribution logic and the physical layer downstream use these outputs to decide what to transmit.

All horizontal times are counted in byte cycles, not pixels. In non-burst operation the active part of a line is split into a programmed number of chunks. Each chunk is one pixel packet, optionally followed by a null filler packet. In burst operation the whole active line goes out as a single pixel packet. Each packet's duration is its programmed size plus a fixed header allowance of `HDR_CYC` cycles (default 6).

Configuration is taken from the input words while the soft-reset input is low. It is then held unchanged while the sequencer runs.

Top module: `vid_frame_seq`

## Requirements
- R1: While `rst` is high or `soft_rst_n` is low, the outputs read `region_o`=0 (stopped), `vphase_o`=0, and `lp_ok_o`, `sync_stb_o`, `pix_stb_o`, `fill_stb_o` all 0. On the first clock edge with `soft_rst_n` high, the outputs show the first cycle of the first line of a frame.
- R2: A line lasts `cfg_line_cyc` byte cycles. `sync_stb_o` pulses on its first cycle. The first `cfg_hblank[31:16]` cycles carry region 1 (sync), and the next `cfg_hblank[15:0]` cycles carry region 2 (back porch).
- R3: A frame runs through the vertical phases in this order: sync (`vphase_o`=0, `cfg_vblank[29:20]` lines), back porch (1, `cfg_vblank[19:10]` lines), active (2, `cfg_vact` lines) and front porch (3, `cfg_vblank[9:0]` lines). It then repeats. A phase with a zero line count is skipped, and `vphase_o` changes only at a line start.
- R4: In a non-burst active line, `cfg_pkt[31:16]` chunks follow the back porch, with a count of 0 acting as 1. Each chunk is a pixel packet of `cfg_pkt[15:0]`+`HDR_CYC` cycles (region 3), followed by a filler packet of `cfg_null`+`HDR_CYC` cycles (region 4). `pix_stb_o` and `fill_stb_o` pulse on the first cycle of each packet.
- R5: When `cfg_null` is 0, no filler packet is produced, and pixel packets follow each other directly.
- R6: When `cfg_burst` is 1, an active line carries exactly one pixel packet and no filler packet, whatever the chunk count and null size are.
- R7: The cycles after the back porch that carry no packet are front porch (region 5). Lines outside the active phase carry no packets. A packet still running when the line time runs out is cut off at the line end.
- R8: `lp_ok_o` is 0 in regions 0, 1, 3 and 4. In back porch and front porch of an active line it equals `cfg_lp_en[3]` AND (`cfg_lp_en[1]` for back porch, `cfg_lp_en[0]` for front porch). In lines of the sync, back-porch and front-porch phases it equals `cfg_lp_en[5]`, `cfg_lp_en[4]` and `cfg_lp_en[2]` respectively.
- R9: Changes on any configuration input while `soft_rst_n` is high have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst_n | input | 1 | Low: stop, return to frame start, capture configuration |
| cfg_line_cyc | input | CNT_W | Total line time in byte cycles |
| cfg_hblank | input | 2*CNT_W | [31:16] sync time, [15:0] back-porch time, byte cycles |
| cfg_vblank | input | 3*VB_W | [29:20] sync lines, [19:10] back-porch lines, [9:0] front-porch lines |
| cfg_vact | input | VACT_W | Active lines per frame |
| cfg_pkt | input | 2*CNT_W | [31:16] chunks per line, [15:0] pixel packet size |
| cfg_null | input | NULL_W | Null filler packet size, 0 = none |
| cfg_burst | input | 1 | 1 = one packet per active line |
| cfg_lp_en | input | 6 | Low-power permits: 0 hfp, 1 hbp, 2 vfp, 3 vact, 4 vbp, 5 vsync |
| region_o | output | 3 | 0 stop, 1 sync, 2 back porch, 3 pixel, 4 filler, 5 front porch |
| vphase_o | output | 2 | Vertical phase of current line |
| lp_ok_o | output | 1 | Link may enter low power this cycle |
| sync_stb_o | output | 1 | First cycle of a line |
| pix_stb_o | output | 1 | First cycle of a pixel packet |
| fill_stb_o | output | 1 | First cycle of a filler packet |

## Verification
The bench compares every output on every cycle with an arithmetic model that decodes the cycle index into line, phase and line offset. It does this across a sweep of chunk counts 0 to 3, null sizes 0 to 2 and both burst settings. That sweep separates the chunk, filler and burst paths from one another. A second sweep runs all 64 low-power permit masks. It shows that each permit bit gates exactly its own region and phase. Dedicated settings cover zero-line vertical phases (skip order), a line too short for its packets (cut-off) and configuration changes made mid-run (ignored).

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    RG_STOP  = 3'd0,
    RG_SYNC  = 3'd1,
    RG_BACK  = 3'd2,
    RG_PIXEL = 3'd3,
    RG_FILL  = 3'd4,
    RG_FRONT = 3'd5
  } region_t;

  typedef enum logic [1:0] {
    CH_WAIT, CH_PIX, CH_FILL, CH_DONE
  } chunk_st_t;

  localparam logic [1:0] VP_SYNC  = 2'd0;
  localparam logic [1:0] VP_BACK  = 2'd1;
  localparam logic [1:0] VP_ACT   = 2'd2;
  localparam logic [1:0] VP_FRONT = 2'd3;

  localparam int LP_HFP   = 0;
  localparam int LP_HBP   = 1;
  localparam int LP_VFP   = 2;
  localparam int LP_VACT  = 3;
  localparam int LP_VBP   = 4;
  localparam int LP_VSYNC = 5;
  localparam int LP_BITS  = 6;
endpackage

// File: rtl/vfs_cfg_latch.sv
module vfs_cfg_latch #(
  parameter int CNT_W  = 16,
  parameter int VB_W   = 10,
  parameter int VACT_W = 12,
  parameter int NULL_W = 10,
  parameter int LP_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst_n,
  input  logic [CNT_W-1:0]      cfg_line_cyc,
  input  logic [2*CNT_W-1:0]    cfg_hblank,
  input  logic [3*VB_W-1:0]     cfg_vblank,
  input  logic [VACT_W-1:0]     cfg_vact,
  input  logic [2*CNT_W-1:0]    cfg_pkt,
  input  logic [NULL_W-1:0]     cfg_null,
  input  logic                  cfg_burst,
  input  logic [LP_W-1:0]       cfg_lp_en,
  output logic [CNT_W-1:0]      s_line,
  output logic [CNT_W-1:0]      s_hs,
  output logic [CNT_W-1:0]      s_hbp,
  output logic [VB_W-1:0]       s_vs,
  output logic [VB_W-1:0]       s_vbp,
  output logic [VB_W-1:0]       s_vfp,
  output logic [VACT_W-1:0]     s_vact,
  output logic [CNT_W-1:0]      s_pkt,
  output logic [CNT_W-1:0]      s_chunks,
  output logic [NULL_W-1:0]     s_null,
  output logic                  s_burst,
  output logic [LP_W-1:0]       s_lp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_line   <= '0;
      s_hs     <= '0;
      s_hbp    <= '0;
      s_vs     <= '0;
      s_vbp    <= '0;
      s_vfp    <= '0;
      s_vact   <= '0;
      s_pkt    <= '0;
      s_chunks <= '0;
      s_null   <= '0;
      s_burst  <= 1'b0;
      s_lp     <= '0;
    end else if (!soft_rst_n) begin
      s_line   <= cfg_line_cyc;
      s_hs     <= cfg_hblank[2*CNT_W-1:CNT_W];
      s_hbp    <= cfg_hblank[CNT_W-1:0];
      s_vs     <= cfg_vblank[3*VB_W-1:2*VB_W];
      s_vbp    <= cfg_vblank[2*VB_W-1:VB_W];
      s_vfp    <= cfg_vblank[VB_W-1:0];
      s_vact   <= cfg_vact;
      s_pkt    <= cfg_pkt[CNT_W-1:0];
      s_chunks <= cfg_pkt[2*CNT_W-1:CNT_W];
      s_null   <= cfg_null;
      s_burst  <= cfg_burst;
      s_lp     <= cfg_lp_en;
    end
  end
endmodule

// File: rtl/vfs_vert.sv
module vfs_vert #(
  parameter int VB_W   = 10,
  parameter int VACT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              line_end,
  input  logic [VB_W-1:0]   s_vs,
  input  logic [VB_W-1:0]   s_vbp,
  input  logic [VACT_W-1:0] s_vact,
  input  logic [VB_W-1:0]   s_vfp,
  output logic [1:0]        phase,
  output logic              act_line
);
  import vfs_pkg::*;
  localparam int VCNT_W = (VB_W > VACT_W) ? VB_W : VACT_W;

  logic [VCNT_W-1:0] cnt_arr [4];
  logic [VCNT_W-1:0] vcnt_q;
  logic [1:0]        ph_q, eff, nxt, cand_a, cand_b;
  logic              hit_a, hit_b;

  assign cnt_arr[0] = VCNT_W'(s_vs);
  assign cnt_arr[1] = VCNT_W'(s_vbp);
  assign cnt_arr[2] = VCNT_W'(s_vact);
  assign cnt_arr[3] = VCNT_W'(s_vfp);

  // effective phase: first phase with lines, starting at the stored one
  always_comb begin
    eff    = ph_q;
    hit_a  = 1'b0;
    cand_a = ph_q;
    for (int k = 0; k < 4; k++) begin
      cand_a = ph_q + 2'(k);
      if (!hit_a && cnt_arr[cand_a] != '0) begin
        eff   = cand_a;
        hit_a = 1'b1;
      end
    end
  end

  // phase that follows the effective one
  always_comb begin
    nxt    = VP_SYNC;
    hit_b  = 1'b0;
    cand_b = eff;
    for (int k = 1; k <= 4; k++) begin
      cand_b = eff + 2'(k);
      if (!hit_b && cnt_arr[cand_b] != '0) begin
        nxt   = cand_b;
        hit_b = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph_q   <= VP_SYNC;
      vcnt_q <= '0;
    end else if (line_end) begin
      if (({1'b0, vcnt_q} + 1'b1) >= {1'b0, cnt_arr[eff]}) begin
        ph_q   <= nxt;
        vcnt_q <= '0;
      end else begin
        ph_q   <= eff;
        vcnt_q <= vcnt_q + 1'b1;
      end
    end
  end

  assign phase    = eff;
  assign act_line = (eff == VP_ACT);
endmodule

// File: rtl/vfs_horiz.sv
module vfs_horiz #(
  parameter int CNT_W   = 16,
  parameter int NULL_W  = 10,
  parameter int HDR_CYC = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  act_line,
  input  logic [CNT_W-1:0]      s_line,
  input  logic [CNT_W-1:0]      s_hs,
  input  logic [CNT_W-1:0]      s_hbp,
  input  logic [CNT_W-1:0]      s_pkt,
  input  logic [CNT_W-1:0]      s_chunks,
  input  logic [NULL_W-1:0]     s_null,
  input  logic                  s_burst,
  output vfs_pkg::region_t      region_c,
  output logic                  line_end,
  output logic                  sync_c,
  output logic                  pix_c,
  output logic                  fill_c
);
  import vfs_pkg::*;
  localparam int SEG_W = CNT_W + 1;

  logic [CNT_W-1:0] hpos_q, idx_q, cur_idx, nx_idx, n_eff;
  logic [SEG_W-1:0] left_q, cur_left, nx_left, pix_len, fill_len, back_end;
  chunk_st_t        st_q, cur_st, nx_st;
  logic             starting;

  assign pix_len  = SEG_W'(s_pkt) + SEG_W'(HDR_CYC);
  assign fill_len = (s_burst || s_null == '0) ? '0 : SEG_W'(s_null) + SEG_W'(HDR_CYC);
  assign n_eff    = (s_burst || s_chunks == '0) ? CNT_W'(1) : s_chunks;
  assign back_end = SEG_W'(s_hs) + SEG_W'(s_hbp);
  assign line_end = (SEG_W'(hpos_q) + 1'b1) >= SEG_W'(s_line);
  assign starting = act_line && (st_q == CH_WAIT) && (SEG_W'(hpos_q) == back_end);

  always_comb begin
    cur_st   = starting ? CH_PIX : st_q;
    cur_left = starting ? pix_len : left_q;
    cur_idx  = starting ? '0 : idx_q;
  end

  always_comb begin
    nx_st   = cur_st;
    nx_left = cur_left;
    nx_idx  = cur_idx;
    if (cur_st == CH_PIX || cur_st == CH_FILL) begin
      if (cur_left > SEG_W'(1)) begin
        nx_left = cur_left - 1'b1;
      end else if (cur_st == CH_PIX && fill_len != '0) begin
        nx_st   = CH_FILL;
        nx_left = fill_len;
      end else if (({1'b0, cur_idx} + 1'b1) < {1'b0, n_eff}) begin
        nx_st   = CH_PIX;
        nx_left = pix_len;
        nx_idx  = cur_idx + 1'b1;
      end else begin
        nx_st   = CH_DONE;
      end
    end
  end

  always_comb begin
    if (hpos_q < s_hs)                    region_c = RG_SYNC;
    else if (SEG_W'(hpos_q) < back_end)   region_c = RG_BACK;
    else if (cur_st == CH_PIX)            region_c = RG_PIXEL;
    else if (cur_st == CH_FILL)           region_c = RG_FILL;
    else                                  region_c = RG_FRONT;
  end

  assign sync_c = (hpos_q == '0);
  assign pix_c  = (cur_st == CH_PIX)  && (cur_left == pix_len);
  assign fill_c = (cur_st == CH_FILL) && (cur_left == fill_len);

  always_ff @(posedge clk) begin
    if (rst || !run || line_end) begin
      hpos_q <= '0;
      st_q   <= CH_WAIT;
      left_q <= '0;
      idx_q  <= '0;
    end else begin
      hpos_q <= hpos_q + 1'b1;
      st_q   <= nx_st;
      left_q <= nx_left;
      idx_q  <= nx_idx;
    end
  end
endmodule

// File: rtl/vfs_out.sv
module vfs_out (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  vfs_pkg::region_t region_c,
  input  logic [1:0]       phase,
  input  logic [5:0]       s_lp,
  input  logic             sync_c,
  input  logic             pix_c,
  input  logic             fill_c,
  output logic [2:0]       region_o,
  output logic [1:0]       vphase_o,
  output logic             lp_ok_o,
  output logic             sync_stb_o,
  output logic             pix_stb_o,
  output logic             fill_stb_o
);
  import vfs_pkg::*;
  logic hbit, lp_c;

  always_comb begin
    hbit = (region_c == RG_BACK) ? s_lp[LP_HBP] : s_lp[LP_HFP];
    lp_c = 1'b0;
    if (region_c == RG_BACK || region_c == RG_FRONT) begin
      case (phase)
        VP_ACT:  lp_c = s_lp[LP_VACT] & hbit;
        VP_SYNC: lp_c = s_lp[LP_VSYNC];
        VP_BACK: lp_c = s_lp[LP_VBP];
        default: lp_c = s_lp[LP_VFP];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      region_o   <= RG_STOP;
      vphase_o   <= VP_SYNC;
      lp_ok_o    <= 1'b0;
      sync_stb_o <= 1'b0;
      pix_stb_o  <= 1'b0;
      fill_stb_o <= 1'b0;
    end else begin
      region_o   <= region_c;
      vphase_o   <= phase;
      lp_ok_o    <= lp_c;
      sync_stb_o <= sync_c;
      pix_stb_o  <= pix_c;
      fill_stb_o <= fill_c;
    end
  end
endmodule

// File: rtl/vid_frame_seq.sv
module vid_frame_seq #(
  parameter int CNT_W   = 16,
  parameter int VB_W    = 10,
  parameter int VACT_W  = 12,
  parameter int NULL_W  = 10,
  parameter int HDR_CYC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst_n,
  input  logic [CNT_W-1:0]   cfg_line_cyc,
  input  logic [2*CNT_W-1:0] cfg_hblank,
  input  logic [3*VB_W-1:0]  cfg_vblank,
  input  logic [VACT_W-1:0]  cfg_vact,
  input  logic [2*CNT_W-1:0] cfg_pkt,
  input  logic [NULL_W-1:0]  cfg_null,
  input  logic               cfg_burst,
  input  logic [5:0]         cfg_lp_en,
  output logic [2:0]         region_o,
  output logic [1:0]         vphase_o,
  output logic               lp_ok_o,
  output logic               sync_stb_o,
  output logic               pix_stb_o,
  output logic               fill_stb_o
);
  import vfs_pkg::*;

  logic [CNT_W-1:0]  s_line, s_hs, s_hbp, s_pkt, s_chunks;
  logic [VB_W-1:0]   s_vs, s_vbp, s_vfp;
  logic [VACT_W-1:0] s_vact;
  logic [NULL_W-1:0] s_null;
  logic              s_burst;
  logic [5:0]        s_lp;
  logic [1:0]        phase;
  logic              act_line, line_end, sync_c, pix_c, fill_c;
  region_t           region_c;

  vfs_cfg_latch #(.CNT_W(CNT_W), .VB_W(VB_W), .VACT_W(VACT_W), .NULL_W(NULL_W), .LP_W(LP_BITS)) u_cfg (
    .clk(clk), .rst(rst), .soft_rst_n(soft_rst_n),
    .cfg_line_cyc(cfg_line_cyc), .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank),
    .cfg_vact(cfg_vact), .cfg_pkt(cfg_pkt), .cfg_null(cfg_null),
    .cfg_burst(cfg_burst), .cfg_lp_en(cfg_lp_en),
    .s_line(s_line), .s_hs(s_hs), .s_hbp(s_hbp), .s_vs(s_vs), .s_vbp(s_vbp),
    .s_vfp(s_vfp), .s_vact(s_vact), .s_pkt(s_pkt), .s_chunks(s_chunks),
    .s_null(s_null), .s_burst(s_burst), .s_lp(s_lp)
  );

  vfs_vert #(.VB_W(VB_W), .VACT_W(VACT_W)) u_vert (
    .clk(clk), .rst(rst), .run(soft_rst_n), .line_end(line_end),
    .s_vs(s_vs), .s_vbp(s_vbp), .s_vact(s_vact), .s_vfp(s_vfp),
    .phase(phase), .act_line(act_line)
  );

  vfs_horiz #(.CNT_W(CNT_W), .NULL_W(NULL_W), .HDR_CYC(HDR_CYC)) u_horiz (
    .clk(clk), .rst(rst), .run(soft_rst_n), .act_line(act_line),
    .s_line(s_line), .s_hs(s_hs), .s_hbp(s_hbp), .s_pkt(s_pkt),
    .s_chunks(s_chunks), .s_null(s_null), .s_burst(s_burst),
    .region_c(region_c), .line_end(line_end),
    .sync_c(sync_c), .pix_c(pix_c), .fill_c(fill_c)
  );

  vfs_out u_out (
    .clk(clk), .rst(rst), .run(soft_rst_n), .region_c(region_c),
    .phase(phase), .s_lp(s_lp), .sync_c(sync_c), .pix_c(pix_c), .fill_c(fill_c),
    .region_o(region_o), .vphase_o(vphase_o), .lp_ok_o(lp_ok_o),
    .sync_stb_o(sync_stb_o), .pix_stb_o(pix_stb_o), .fill_stb_o(fill_stb_o)
  );
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               soft_rst_n,
  input logic [2:0]         region_o,
  input logic [1:0]         vphase_o,
  input logic               lp_ok_o,
  input logic               sync_stb_o,
  input logic               pix_stb_o,
  input logic               fill_stb_o,
  input logic [CNT_W-1:0]   snap_line,
  input logic [CNT_W-1:0]   snap_pkt
);
  assert_stop_when_held_R1: assert property (@(posedge clk) disable iff (rst)
    !soft_rst_n |=> (region_o == 3'd0 && !lp_ok_o && !sync_stb_o && !pix_stb_o && !fill_stb_o));

  assert_phase_moves_at_line_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(vphase_o) |-> (sync_stb_o || region_o == 3'd0));

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pix_stb_o, fill_stb_o}));

  assert_pix_in_pixel_R4: assert property (@(posedge clk) disable iff (rst)
    pix_stb_o |-> region_o == 3'd3);

  assert_fill_in_filler_R4: assert property (@(posedge clk) disable iff (rst)
    fill_stb_o |-> region_o == 3'd4);

  assert_blank_lines_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (vphase_o != 2'd2) |-> (region_o != 3'd3 && region_o != 3'd4));

  assert_no_lp_in_packets_R8: assert property (@(posedge clk) disable iff (rst)
    (region_o == 3'd0 || region_o == 3'd1 || region_o == 3'd3 || region_o == 3'd4) |-> !lp_ok_o);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && soft_rst_n && $past(soft_rst_n)) |-> ($stable(snap_line) && $stable(snap_pkt)));
endmodule

bind vid_frame_seq vfs_checker #(.CNT_W(CNT_W)) u_vfs_chk (
  .clk(clk), .rst(rst), .soft_rst_n(soft_rst_n),
  .region_o(region_o), .vphase_o(vphase_o), .lp_ok_o(lp_ok_o),
  .sync_stb_o(sync_stb_o), .pix_stb_o(pix_stb_o), .fill_stb_o(fill_stb_o),
  .snap_line(s_line), .snap_pkt(s_pkt)
);

// File: tb/test_vid_frame_seq.sv
module test_vid_frame_seq;
  localparam int HDR = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst_n = 1'b0;
  logic [15:0] cfg_line_cyc = '0;
  logic [31:0] cfg_hblank = '0;
  logic [29:0] cfg_vblank = '0;
  logic [11:0] cfg_vact = '0;
  logic [31:0] cfg_pkt = '0;
  logic [9:0]  cfg_null = '0;
  logic        cfg_burst = 1'b0;
  logic [5:0]  cfg_lp_en = '0;
  logic [2:0]  region_o;
  logic [1:0]  vphase_o;
  logic        lp_ok_o, sync_stb_o, pix_stb_o, fill_stb_o;

  int total = 0;
  int bad = 0;

  int m_L, m_hs, m_hb, m_vs, m_vb, m_va, m_vf, m_pkt, m_ch, m_nul, m_burst;
  logic [5:0] m_lp;

  always #5 clk = ~clk;

  vid_frame_seq i_vid_frame_seq (
    .clk(clk), .rst(rst), .soft_rst_n(soft_rst_n),
    .cfg_line_cyc(cfg_line_cyc), .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank),
    .cfg_vact(cfg_vact), .cfg_pkt(cfg_pkt), .cfg_null(cfg_null),
    .cfg_burst(cfg_burst), .cfg_lp_en(cfg_lp_en),
    .region_o(region_o), .vphase_o(vphase_o), .lp_ok_o(lp_ok_o),
    .sync_stb_o(sync_stb_o), .pix_stb_o(pix_stb_o), .fill_stb_o(fill_stb_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int L, input int hs, input int hb, input int vs, input int vb,
                         input int va, input int vf, input int pkt, input int ch, input int nul,
                         input int burst, input logic [5:0] lp);
    m_L = L; m_hs = hs; m_hb = hb; m_vs = vs; m_vb = vb; m_va = va; m_vf = vf;
    m_pkt = pkt; m_ch = ch; m_nul = nul; m_burst = burst; m_lp = lp;
    cfg_line_cyc = 16'(L);
    cfg_hblank   = {16'(hs), 16'(hb)};
    cfg_vblank   = {10'(vs), 10'(vb), 10'(vf)};
    cfg_vact     = 12'(va);
    cfg_pkt      = {16'(ch), 16'(pkt)};
    cfg_null     = 10'(nul);
    cfg_burst    = burst[0];
    cfg_lp_en    = lp;
  endtask

  // arithmetic model of one byte cycle, s counted from release
  task automatic model(input int s, output int rg, output int ph, output int lp,
                       output int sy, output int px, output int fl);
    int t, li, hp, base, off, plen, flen, n;
    t  = m_vs + m_vb + m_va + m_vf;
    li = (s / m_L) % t;
    hp = s % m_L;
    if (li < m_vs) ph = 0;
    else if (li < m_vs + m_vb) ph = 1;
    else if (li < m_vs + m_vb + m_va) ph = 2;
    else ph = 3;
    sy = (hp == 0) ? 1 : 0;
    px = 0; fl = 0;
    base = m_hs + m_hb;
    if (hp < m_hs) rg = 1;
    else if (hp < base) rg = 2;
    else begin
      rg = 5;
      if (ph == 2) begin
        plen = m_pkt + HDR;
        flen = (m_burst != 0 || m_nul == 0) ? 0 : m_nul + HDR;
        n    = (m_burst != 0 || m_ch == 0) ? 1 : m_ch;
        off  = hp - base;
        for (int c = 0; c < n && rg == 5; c++) begin
          if (off < plen) begin
            rg = 3; px = (off == 0) ? 1 : 0;
          end else begin
            off -= plen;
            if (off < flen) begin
              rg = 4; fl = (off == 0) ? 1 : 0;
            end else off -= flen;
          end
        end
      end
    end
    lp = 0;
    if (rg == 2 || rg == 5) begin
      if (ph == 2) lp = int'(m_lp[3] & ((rg == 2) ? m_lp[1] : m_lp[0]));
      else if (ph == 0) lp = int'(m_lp[5]);
      else if (ph == 1) lp = int'(m_lp[4]);
      else lp = int'(m_lp[2]);
    end
  endtask

  // stop, capture the current configuration, release and compare every cycle
  task automatic run_seq(input string tag, input int slots, input int scramble_at);
    int rg, ph, lp, sy, px, fl;
    repeat (2) @(negedge clk);
    chk("R1", "stopped region", int'(region_o), 0);
    chk("R1", "stopped strobes", int'({sync_stb_o, pix_stb_o, fill_stb_o, lp_ok_o}), 0);
    soft_rst_n = 1'b1;
    for (int s = 0; s < slots; s++) begin
      @(negedge clk);
      model(s, rg, ph, lp, sy, px, fl);
      if (s == 0) chk("R1", "first cycle region", int'(region_o), rg);
      chk(tag, "region", int'(region_o), rg);
      chk("R3", "vphase", int'(vphase_o), ph);
      chk("R8", "lp_ok", int'(lp_ok_o), lp);
      chk("R2", "sync_stb", int'(sync_stb_o), sy);
      chk(tag, "pix_stb", int'(pix_stb_o), px);
      chk(tag, "fill_stb", int'(fill_stb_o), fl);
      if (s == scramble_at) begin
        // R9: new values while running must be ignored
        cfg_line_cyc = 16'd7;
        cfg_hblank   = {16'd1, 16'd1};
        cfg_vblank   = {10'd0, 10'd0, 10'd5};
        cfg_pkt      = {16'd9, 16'd1};
        cfg_null     = 10'd0;
        cfg_burst    = 1'b1;
        cfg_lp_en    = ~m_lp;
      end
    end
    @(negedge clk);
    soft_rst_n = 1'b0;
  endtask

  initial begin
    repeat (170000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "reset region", int'(region_o), 0);
    chk("R1", "reset outputs", int'({vphase_o, lp_ok_o, sync_stb_o, pix_stb_o, fill_stb_o}), 0);
    rst = 1'b0;

    // R4: two chunks with filler packets
    set_cfg(60, 3, 4, 1, 1, 2, 1, 4, 2, 2, 0, 6'h3F);
    run_seq("R4", 600, -1);
    // R9: same setting, inputs disturbed while running
    soft_rst_n = 1'b0;
    set_cfg(60, 3, 4, 1, 1, 2, 1, 4, 2, 2, 0, 6'h3F);
    run_seq("R9", 600, 130);
    // R5: no filler packets
    set_cfg(60, 3, 4, 1, 1, 2, 1, 5, 3, 0, 0, 6'h15);
    run_seq("R5", 600, -1);
    // R6: burst ignores chunk count and null size
    set_cfg(60, 3, 4, 1, 1, 2, 1, 20, 3, 5, 1, 6'h2A);
    run_seq("R6", 600, -1);
    // R3: zero-line phases are skipped, chunk count 0 acts as 1
    set_cfg(40, 2, 2, 0, 2, 1, 0, 3, 0, 1, 0, 6'h3F);
    run_seq("R3", 480, -1);
    // R7: packets cut off by a short line
    set_cfg(20, 2, 2, 1, 0, 2, 1, 10, 2, 3, 0, 6'h3F);
    run_seq("R7", 320, -1);
    // R8: every low-power permit mask
    for (int m = 0; m < 64; m++) begin
      set_cfg(30, 2, 3, 1, 1, 1, 1, 2, 1, 1, 0, 6'(m));
      run_seq("R8", 120, -1);
    end
    // R4/R6: sweep chunks, null size and burst
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 3; n++) begin
          set_cfg(80, 2, 3, 1, 0, 2, 0, 3, c, n, b, 6'h0B);
          run_seq((b != 0) ? "R6" : "R4", 240, -1);
        end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule